// File: doc/BRIEF.md
# Wormhole Flit Packer with Source Tagging

The block sits between a processing core and the local port of a 2D-mesh router. The core hands over 32-bit data words, each with a destination node number. The words wait in a small first-in first-out store, so the core can keep producing while an earlier word is still being framed. The framing state machine takes one word at a time and sends it as a four-flit wormhole packet. The flits go out in this order: a header with the XY hop definition, a flit that names this node as the source, the upper half of the word, and a trailer with the lower half. Each flit is offered with a valid line and stays on the port until the router returns acknowledge.

The hop definition comes from a static table. The table is built at elaboration from the mesh size and this node's own number. Node number n sits at column n mod MESH_X and row n div MESH_X.

The framing machine has five states:
- `ST_IDLE` waits for a stored word. It moves to `ST_HEAD` in the cycle the store is non-empty and pops that word.
- `ST_HEAD`, `ST_SRC` and `ST_UPPER` each move to the next state in the cycle their flit is acknowledged.
- `ST_TAIL` returns to `ST_IDLE` on acknowledge.
- Without acknowledge, every state holds.

Top module: `noc_flit_packer`

## Requirements
- R1: `flit_out` is DATA_W+2 bits wide. The top two bits are the flit kind: 2'b10 header, 2'b00 body (source and upper half), 2'b01 trailer. Code 2'b11 is never sent.
- R2: Header data bits are laid out as follows, counted relative to node SRC_ID:
  - bit 15 is the X direction (1 = toward lower column);
  - bits 14:8 are the X hop count;
  - bit 7 is the Y direction (1 = toward lower row);
  - bits 6:0 are the Y hop count.
  A destination equal to SRC_ID gives all zeros.
- R3: The second flit carries SRC_ID in its low data bits, and every other data bit is zero.
- R4: While `flit_val` is high and `flit_ack` is low, `flit_val` and `flit_out` stay unchanged on the next cycle.
- R5: Every packet is exactly four flits in this order: header, source, upper 16 bits of the word, then trailer with the lower 16 bits. The machine advances one flit per acknowledged cycle.
- R6: `flit_val` is low whenever no packet is in progress. A packet starts only when the store holds a word. The first valid flit after an idle period is a header.
- R7: In the cycle after the trailer is acknowledged, `flit_val` is low.
- R8: `core_ready` is low while the store holds FIFO_DEPTH words, so at most FIFO_DEPTH+1 words are taken while the router stalls. A word offered while `core_ready` is low is ignored. Accepted words are sent in arrival order with none lost.
- R9: During and right after reset, `flit_val` is low and `core_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_valid | input | 1 | Core offers a word this cycle |
| core_word | input | WORD_W (32) | Data word from the core |
| core_dest | input | NODE_W (4) | Destination node number |
| core_ready | output | 1 | Store can take a word this cycle |
| flit_out | output | FLIT_W (18) | Flit toward the router |
| flit_val | output | 1 | Flit on `flit_out` is valid |
| flit_ack | input | 1 | Router takes the flit at this edge |

## Verification
The bench uses the defaults: a 4x4 mesh, this node at number 5 (column 1, row 1), 16-bit flit data and a four-word store. From column 1, row 1, destinations in both directions are reachable, along with zero hops (itself) and the far corner of two hops each way. A four-word store is small enough to fill within a few cycles of stalled acknowledge, so the refusal path and the FIFO_DEPTH+1 acceptance limit are exercised. Acknowledge is driven always high, pseudo-randomly and held low, which covers back-to-back flits as well as the hold behaviour.

// File: rtl/flitpk_pkg.sv
package flitpk_pkg;

    typedef enum logic [1:0] {
        CC_BODY = 2'b00,
        CC_TAIL = 2'b01,
        CC_HEAD = 2'b10
    } flit_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_SRC,
        ST_UPPER,
        ST_TAIL
    } pk_state_e;

endpackage

// File: rtl/pk_word_fifo.sv
module pk_word_fifo #(
    parameter int W     = 36,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == FULLC);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/pk_route_rom.sv
module pk_route_rom #(
    parameter int MESH_X = 4,
    parameter int MESH_Y = 4,
    parameter int SRC_ID = 5,
    parameter int NODE_W = 4,
    parameter int DATA_W = 16
) (
    input  logic [NODE_W-1:0] dest,
    output logic [DATA_W-1:0] hop_field
);
    localparam int NODES = MESH_X * MESH_Y;
    localparam int HALF  = DATA_W / 2;
    localparam int MAG_W = HALF - 1;
    localparam int SX    = SRC_ID % MESH_X;
    localparam int SY    = SRC_ID / MESH_X;

    logic [DATA_W-1:0] table_q [NODES];

    for (genvar g = 0; g < NODES; g++) begin : g_entry
        localparam int DX = (g % MESH_X) - SX;
        localparam int DY = (g / MESH_X) - SY;
        localparam logic [MAG_W-1:0] XM = MAG_W'((DX < 0) ? -DX : DX);
        localparam logic [MAG_W-1:0] YM = MAG_W'((DY < 0) ? -DY : DY);
        localparam logic XN = (DX < 0);
        localparam logic YN = (DY < 0);
        assign table_q[g] = DATA_W'({XN, XM, YN, YM});
    end

    always_comb begin
        if (32'(dest) < NODES) begin
            hop_field = table_q[dest];
        end else begin
            hop_field = '0;
        end
    end
endmodule

// File: rtl/pk_frame_fsm.sv
module pk_frame_fsm
    import flitpk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NODE_W = 4,
    parameter int SRC_ID = 5,
    localparam int WORD_W = 2 * DATA_W,
    localparam int FLIT_W = DATA_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fifo_empty,
    input  logic [NODE_W+WORD_W-1:0] fifo_word,
    output logic                     fifo_pop,
    output logic [NODE_W-1:0]        dest_q,
    input  logic [DATA_W-1:0]        hop_field,
    output logic [FLIT_W-1:0]        flit,
    output logic                     val,
    input  logic                     ack
);
    localparam logic [DATA_W-1:0] SRC_FIELD = DATA_W'(SRC_ID);

    pk_state_e         state, next_state;
    logic [WORD_W-1:0] word_q;

    always_comb begin
        next_state = state;
        fifo_pop   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (!fifo_empty) begin
                    fifo_pop   = 1'b1;
                    next_state = ST_HEAD;
                end
            end
            ST_HEAD:  if (ack) next_state = ST_SRC;
            ST_SRC:   if (ack) next_state = ST_UPPER;
            ST_UPPER: if (ack) next_state = ST_TAIL;
            ST_TAIL:  if (ack) next_state = ST_IDLE;
            default:  next_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= next_state;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            dest_q <= '0;
        end else if (fifo_pop) begin
            {dest_q, word_q} <= fifo_word;
        end
    end

    always_comb begin
        val  = 1'b1;
        flit = '0;
        unique case (state)
            ST_IDLE: begin
                val  = 1'b0;
                flit = '0;
            end
            ST_HEAD:  flit = {CC_HEAD, hop_field};
            ST_SRC:   flit = {CC_BODY, SRC_FIELD};
            ST_UPPER: flit = {CC_BODY, word_q[WORD_W-1:DATA_W]};
            ST_TAIL:  flit = {CC_TAIL, word_q[DATA_W-1:0]};
            default: begin
                val  = 1'b0;
                flit = '0;
            end
        endcase
    end
endmodule

// File: rtl/noc_flit_packer.sv
module noc_flit_packer #(
    parameter int DATA_W     = 16,
    parameter int MESH_X     = 4,
    parameter int MESH_Y     = 4,
    parameter int SRC_ID     = 5,
    parameter int FIFO_DEPTH = 4,
    localparam int WORD_W = 2 * DATA_W,
    localparam int NODE_W = (MESH_X * MESH_Y > 1) ? $clog2(MESH_X * MESH_Y) : 1,
    localparam int FLIT_W = DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_valid,
    input  logic [WORD_W-1:0] core_word,
    input  logic [NODE_W-1:0] core_dest,
    output logic              core_ready,
    output logic [FLIT_W-1:0] flit_out,
    output logic              flit_val,
    input  logic              flit_ack
);
    localparam int ENTRY_W = NODE_W + WORD_W;

    logic               fifo_full, fifo_empty, fifo_pop;
    logic [ENTRY_W-1:0] fifo_word;
    logic [NODE_W-1:0]  dest_q;
    logic [DATA_W-1:0]  hop_field;

    assign core_ready = !fifo_full;

    pk_word_fifo #(
        .W     (ENTRY_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (core_valid),
        .din   ({core_dest, core_word}),
        .pop   (fifo_pop),
        .dout  (fifo_word),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    pk_route_rom #(
        .MESH_X (MESH_X),
        .MESH_Y (MESH_Y),
        .SRC_ID (SRC_ID),
        .NODE_W (NODE_W),
        .DATA_W (DATA_W)
    ) u_route (
        .dest      (dest_q),
        .hop_field (hop_field)
    );

    pk_frame_fsm #(
        .DATA_W (DATA_W),
        .NODE_W (NODE_W),
        .SRC_ID (SRC_ID)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .fifo_word  (fifo_word),
        .fifo_pop   (fifo_pop),
        .dest_q     (dest_q),
        .hop_field  (hop_field),
        .flit       (flit_out),
        .val        (flit_val),
        .ack        (flit_ack)
    );
endmodule

// File: rtl/noc_flit_packer_chk.sv
module noc_flit_packer_chk #(
    parameter int FLIT_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic [FLIT_W-1:0] flit_out,
    input logic              flit_val,
    input logic              flit_ack
);
    logic [1:0] kind;
    assign kind = flit_out[FLIT_W-1:FLIT_W-2];

    a_r1_legal_kind: assert property (@(posedge clk) disable iff (!rst_n)
        flit_val |-> (kind != 2'b11));

    a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_val && !flit_ack) |=> (flit_val && $stable(flit_out)));

    a_r5_source_after_header: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_val && flit_ack && kind == 2'b10) |=> (flit_val && kind == 2'b00));

    a_r6_start_with_header: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flit_val) |-> (kind == 2'b10));

    a_r7_idle_after_trailer: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_val && flit_ack && kind == 2'b01) |=> !flit_val);
endmodule

bind noc_flit_packer noc_flit_packer_chk #(.FLIT_W(FLIT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .flit_out (flit_out),
    .flit_val (flit_val),
    .flit_ack (flit_ack)
);

// File: tb/noc_flit_packer_test.sv
module noc_flit_packer_test;
    localparam int DW = 16;
    localparam int MX = 4;
    localparam int MY = 4;
    localparam int SID = 5;
    localparam int DEP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_valid = 1'b0;
    logic [31:0] core_word = '0;
    logic [3:0]  core_dest = '0;
    logic        core_ready;
    logic [17:0] flit_out;
    logic        flit_val;
    logic        flit_ack = 1'b0;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int ack_mode = 0;
    logic [17:0] exp_q[$];

    noc_flit_packer #(
        .DATA_W(DW), .MESH_X(MX), .MESH_Y(MY), .SRC_ID(SID), .FIFO_DEPTH(DEP)
    ) uut (
        .clk(clk), .rst_n(rst_n), .core_valid(core_valid), .core_word(core_word),
        .core_dest(core_dest), .core_ready(core_ready), .flit_out(flit_out),
        .flit_val(flit_val), .flit_ack(flit_ack)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] hop_of(input int dest);
        int dx, dy;
        logic [15:0] h;
        dx = (dest % MX) - (SID % MX);
        dy = (dest / MX) - (SID / MX);
        h = '0;
        h[15]   = (dx < 0);
        h[14:8] = 7'((dx < 0) ? -dx : dx);
        h[7]    = (dy < 0);
        h[6:0]  = 7'((dy < 0) ? -dy : dy);
        return h;
    endfunction

    // driver: caller starts just after a rising edge; returns just after a rising edge
    task automatic offer(input logic [31:0] w, input logic [3:0] d, output bit taken);
        core_valid = 1'b1;
        core_word  = w;
        core_dest  = d;
        @(negedge clk);
        taken = core_ready;
        if (taken) begin
            exp_q.push_back({2'b10, hop_of(int'(d))});
            exp_q.push_back({2'b00, 16'(SID)});
            exp_q.push_back({2'b00, w[31:16]});
            exp_q.push_back({2'b01, w[15:0]});
        end
        @(posedge clk);
        #1;
        core_valid = 1'b0;
    endtask

    // acknowledge driver, changes away from the sampling edge
    always @(posedge clk) begin
        #1;
        case (ack_mode)
            0:       flit_ack = 1'b1;
            1:       flit_ack = ($urandom_range(0, 2) != 0);
            default: flit_ack = 1'b0;
        endcase
    end

    // monitor / scoreboard
    bit          prev_stall = 1'b0;
    logic [17:0] prev_flit = '0;
    bit          after_tail = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall)
                check(flit_val && flit_out == prev_flit, "R4 hold while stalled",
                      {13'd0, flit_val, flit_out}, {13'd0, 1'b1, prev_flit});
            if (after_tail)
                check(!flit_val, "R7 idle after trailer", 32'(flit_val), 32'd0);
            after_tail = 1'b0;
            if (flit_val && flit_ack) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected flit", 32'(flit_out), 32'd0);
                end else begin
                    logic [17:0] e;
                    e = exp_q.pop_front();
                    check(flit_out == e, "R1/R2/R3/R5 flit content", 32'(flit_out), 32'(e));
                    if (e[17:16] == 2'b01) after_tail = 1'b1;
                end
            end
            prev_stall = flit_val && !flit_ack;
            prev_flit  = flit_out;
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            check(1'b0, "watchdog", 32'(cyc), 32'd0);
            summary();
        end
    end

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
        repeat (4) @(posedge clk);
        #1;
    endtask

    initial begin
        bit tk;
        int taken_n;
        repeat (3) @(negedge clk);
        // R9 reset state
        check(!flit_val, "R9 val low in reset", 32'(flit_val), 32'd0);
        check(core_ready, "R9 ready high in reset", 32'(core_ready), 32'd1);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        check(!flit_val && core_ready, "R9 state after reset", {30'd0, flit_val, core_ready}, 32'd1);
        @(posedge clk); #1;

        // R2 corner destinations, R5 order, always-ack
        ack_mode = 0;
        offer(32'hA1B2_C3D4, 4'd0, tk);
        offer(32'h1234_5678, 4'd15, tk);
        offer(32'hDEAD_BEEF, 4'd5, tk);
        offer(32'h0F0F_F0F0, 4'd3, tk);
        offer(32'h5555_AAAA, 4'd12, tk);
        drain();

        // R6 idle with empty store
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!flit_val, "R6 no packet without data", 32'(flit_val), 32'd0);
        end
        @(posedge clk); #1;

        // random acknowledge, R4 stalls and R5 ordering
        ack_mode = 1;
        for (int i = 0; i < 10; i++) offer(32'hC000_0000 + 32'(i * 32'h0101_0101), 4'(i), tk);
        drain();

        // R8 overflow with stalled router
        ack_mode = 2;
        taken_n = 0;
        for (int i = 0; i < DEP + 3; i++) begin
            offer(32'h7700_0000 + 32'(i), 4'(i + 6), tk);
            if (tk) taken_n++;
        end
        check(taken_n == DEP + 1, "R8 words accepted under stall", 32'(taken_n), 32'(DEP + 1));
        @(negedge clk);
        check(!core_ready, "R8 ready low when full", 32'(core_ready), 32'd0);
        @(posedge clk); #1;
        ack_mode = 1;
        drain();
        check(exp_q.size() == 0, "R8 all accepted words sent", 32'(exp_q.size()), 32'd0);
        @(negedge clk);
        check(core_ready, "R8 ready back after drain", 32'(core_ready), 32'd1);
        summary();
    end
endmodule